// File: doc/BRIEF.md
# SPI Register-Access Frame Decoder

This block is the serial front end of a small sensor register file. A master selects the block by pulling CSB low and clocks 16-bit command frames in on MOSI, MSB first. Each frame names a 6-bit register address, a write flag, an odd-parity bit over the upper byte, and a data byte. A frame is checked once CSB rises. A complete frame with good parity is decoded: a write to a writable register raises a one-cycle strobe with the address and data, and a read selects the register whose contents come back in the next frame. A truncated frame or a frame with bad parity is dropped and raises a frame-error pulse.

While a frame is being clocked in, MISO returns a status byte and then the register chosen by the previous good frame. A master that keeps clocking in whole bytes past the first 16 bits receives registers at successively lower addresses. SCK, CSB and MOSI are sampled by the system clock, so SCK must be well below a quarter of the clock rate. Three writes to the reset register with a fixed key trigger a soft-reset pulse.

Top module: `spi_frame_decoder`

## Requirements
- R1: A frame is sampled MSB first on SCK rising edges while CSB is low; bit 15..10 = address, bit 9 = write flag (1 = write), bit 8 = parity, bit 7..0 = data.
- R2: MISO changes only after an SCK falling edge or a CSB falling edge. The first 8 bits out are the status byte {4'b0, por, ferr, st_flag, sat_flag}. The next 8 bits are the register addressed by the last good frame, which is address 0x00 after reset.
- R3: Read map: 0x00 = REV_ID, 0x01 = control register, 0x02 = status byte, 0x04+i (i = 0..5) = axis_data[8i+7:8i], 0x12/0x13 = temp_data low/high byte, 0x16 = irq_flags, 0x27 = PROD_ID. All other addresses read 0.
- R4: A good write frame to 0x01 or 0x03 raises wr_stb for one clock with wr_addr/wr_data, two clocks after CSB rises. Writes to any other address give no strobe.
- R5: A write to 0x01 loads ctrl_q. Writing 0x00 there also clears the por flag.
- R6: The por flag is 1 after rst_n. Only the 0x00 control write clears it, and a soft reset does not set it.
- R7: If CSB rises after fewer than 16 SCK rises and the count is not a multiple of 8, frame_err pulses and the frame has no effect. Counts of 0 or 8 are dropped silently.
- R8: A frame of 16 or more bits whose upper byte has even parity is handled as in R7: frame_err pulses and nothing changes.
- R9: The ferr status bit is set by a frame error and cleared by the next good frame. It appears in the status byte of the following frame.
- R10: In a frame of 16+8k bits, each byte after the second returns the register one address below the previous byte. Only bits 15..0 form the command.
- R11: Good writes to 0x03 carrying 0x0C, 0x05, 0x0F in consecutive good frames raise soft_rst together with the third strobe. This clears ctrl_q and ferr. Any other good frame or value restarts the key (0x0C restarts at step one).
- R12: wr_stb and frame_err are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| csb | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| axis_data | input | 48 | Six sensor bytes, byte i at address 0x04+i |
| temp_data | input | 16 | Temperature, low byte at 0x12 |
| irq_flags | input | 8 | Interrupt status byte at 0x16 |
| st_flag | input | 1 | Self-test alarm shown in status |
| sat_flag | input | 1 | Saturation alarm shown in status |
| miso | output | 1 | Serial data out |
| wr_stb | output | 1 | Write strobe |
| wr_addr | output | 6 | Address of the write |
| wr_data | output | 8 | Data of the write |
| frame_err | output | 1 | Frame-error pulse |
| soft_rst | output | 1 | Soft-reset pulse |
| ctrl_q | output | 8 | Control register contents |

## Verification
SCK, CSB and MOSI pass through one sampling flop. An edge is then detected in the next cycle. As a result, MISO moves two clocks after an SCK or CSB falling edge, and wr_stb, frame_err and soft_rst appear two clocks after CSB rises, with register and status updates one clock later. The bench holds each SCK level for four clocks and reads MISO just before driving SCK high. After raising CSB it waits twelve clocks, so every pulse and update has settled before it checks the counters and ctrl_q. Pulses are counted on every clock edge, so a missing or doubled strobe changes a count the bench compares.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;

  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int CMD_W      = 16;
  localparam int AXIS_BYTES = 6;
  localparam int TEMP_BYTES = 2;

  localparam logic [ADDR_W-1:0] A_REV  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h01;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h02;
  localparam logic [ADDR_W-1:0] A_RST  = 6'h03;
  localparam logic [ADDR_W-1:0] A_AX0  = 6'h04;
  localparam logic [ADDR_W-1:0] A_TMP0 = 6'h12;
  localparam logic [ADDR_W-1:0] A_IRQ  = 6'h16;
  localparam logic [ADDR_W-1:0] A_PID  = 6'h27;

  localparam logic [DATA_W-1:0] KEY0 = 8'h0C;
  localparam logic [DATA_W-1:0] KEY1 = 8'h05;
  localparam logic [DATA_W-1:0] KEY2 = 8'h0F;

  // upper byte must hold an odd number of ones
  function automatic logic upper_ok(input logic [7:0] b);
    return ^b;
  endfunction

  // truncated frame that is not a whole number of bytes
  function automatic logic frame_short_bad(input int unsigned n);
    return (n < CMD_W) && ((n % 8) != 0);
  endfunction

  function automatic logic addr_writable(input logic [ADDR_W-1:0] a);
    return (a == A_CTRL) || (a == A_RST);
  endfunction

  // next step of the soft-reset key
  function automatic logic [1:0] key_next(input logic [1:0] st, input logic [DATA_W-1:0] d);
    logic [1:0] restart;
    restart = (d == KEY0) ? 2'd1 : 2'd0;
    case (st)
      2'd1:    return (d == KEY1) ? 2'd2 : restart;
      2'd2:    return (d == KEY2) ? 2'd0 : restart;
      default: return restart;
    endcase
  endfunction

  function automatic logic key_done(input logic [1:0] st, input logic [DATA_W-1:0] d);
    return (st == 2'd2) && (d == KEY2);
  endfunction

endpackage

// File: rtl/spi_fd_link.sv
module spi_fd_link
  import spi_fd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck,
  input  logic                 csb,
  input  logic                 mosi,
  input  logic [DATA_W-1:0]    status_byte,
  input  logic [DATA_W-1:0]    rd_byte,
  input  logic [ADDR_W-1:0]    base_addr,
  output logic                 miso,
  output logic [CMD_W-1:0]     cmd_word,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic [ADDR_W-1:0]    rd_ptr,
  output logic                 start_evt,
  output logic                 end_evt,
  output logic                 rise_evt,
  output logic                 fall_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

  logic sck_q, sck_d, csb_q, csb_d, mosi_q;
  logic [CMD_W-2:0]  rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              byte_edge;

  assign rise_evt  = ~csb_q &  sck_q & ~sck_d;
  assign fall_evt  = ~csb_q & ~sck_q &  sck_d;
  assign start_evt = ~csb_q &  csb_d;
  assign end_evt   =  csb_q & ~csb_d;
  assign byte_edge = (bit_cnt[2:0] == 3'd0) && (bit_cnt != '0);
  assign miso      = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      sck_d    <= 1'b0;
      csb_q    <= 1'b1;
      csb_d    <= 1'b1;
      mosi_q   <= 1'b0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      cmd_word <= '0;
      tx_sr    <= '0;
      rd_ptr   <= '0;
    end else begin
      sck_q  <= sck;
      sck_d  <= sck_q;
      csb_q  <= csb;
      csb_d  <= csb_q;
      mosi_q <= mosi;
      if (start_evt) begin
        bit_cnt <= '0;
        tx_sr   <= status_byte;
        rd_ptr  <= base_addr;
      end else begin
        if (rise_evt) begin
          rx_sr <= {rx_sr[CMD_W-3:0], mosi_q};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_LAST) cmd_word <= {rx_sr, mosi_q};
        end
        if (fall_evt) begin
          if (byte_edge) begin
            tx_sr  <= rd_byte;
            rd_ptr <= rd_ptr - 1'b1;
          end else begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_fd_cmd.sv
module spi_fd_cmd
  import spi_fd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 end_evt,
  input  logic [CNT_W-1:0]     bit_cnt,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic                 wr_stb,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 frame_err,
  output logic                 good_frame,
  output logic                 soft_rst,
  output logic [ADDR_W-1:0]    base_addr
);

  logic [ADDR_W-1:0] c_addr;
  logic              c_wr;
  logic [DATA_W-1:0] c_data;
  logic              full_w, len_bad_w, par_bad_w, good_w, key_hit_w;
  logic [1:0]        key_st;

  assign c_addr    = cmd_word[CMD_W-1 -: ADDR_W];
  assign c_wr      = cmd_word[DATA_W+1];
  assign c_data    = cmd_word[DATA_W-1:0];
  assign full_w    = 32'(bit_cnt) >= CMD_W;
  assign len_bad_w = frame_short_bad(32'(bit_cnt));
  assign par_bad_w = full_w && !upper_ok(cmd_word[CMD_W-1:DATA_W]);
  assign good_w    = full_w && !par_bad_w;
  assign key_hit_w = good_w && c_wr && (c_addr == A_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_err  <= 1'b0;
      good_frame <= 1'b0;
      soft_rst   <= 1'b0;
      base_addr  <= A_REV;
      key_st     <= 2'd0;
    end else begin
      wr_stb     <= 1'b0;
      frame_err  <= 1'b0;
      good_frame <= 1'b0;
      soft_rst   <= 1'b0;
      if (end_evt) begin
        frame_err  <= len_bad_w | par_bad_w;
        good_frame <= good_w;
        if (good_w) begin
          base_addr <= c_addr;
          key_st    <= key_hit_w ? key_next(key_st, c_data) : 2'd0;
          soft_rst  <= key_hit_w && key_done(key_st, c_data);
          if (c_wr && addr_writable(c_addr)) begin
            wr_stb  <= 1'b1;
            wr_addr <= c_addr;
            wr_data <= c_data;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_fd_regs.sv
module spi_fd_regs
  import spi_fd_pkg::*;
#(
  parameter logic [7:0] REV_ID  = 8'h13,
  parameter logic [7:0] PROD_ID = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_stb,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        frame_err,
  input  logic                        good_frame,
  input  logic                        soft_rst,
  input  logic [ADDR_W-1:0]           rd_ptr,
  input  logic [8*AXIS_BYTES-1:0]     axis_data,
  input  logic [8*TEMP_BYTES-1:0]     temp_data,
  input  logic [DATA_W-1:0]           irq_flags,
  input  logic                        st_flag,
  input  logic                        sat_flag,
  output logic [DATA_W-1:0]           rd_byte,
  output logic [DATA_W-1:0]           status_byte,
  output logic [DATA_W-1:0]           ctrl_q,
  output logic                        por_flag
);

  logic ferr_q;

  assign status_byte = {4'b0000, por_flag, ferr_q, st_flag, sat_flag};

  always_comb begin
    rd_byte = '0;
    case (rd_ptr)
      A_REV:   rd_byte = REV_ID;
      A_CTRL:  rd_byte = ctrl_q;
      A_STAT:  rd_byte = status_byte;
      A_IRQ:   rd_byte = irq_flags;
      A_PID:   rd_byte = PROD_ID;
      default: rd_byte = '0;
    endcase
    for (int i = 0; i < AXIS_BYTES; i++)
      if (rd_ptr == A_AX0 + ADDR_W'(i)) rd_byte = axis_data[8*i +: 8];
    for (int i = 0; i < TEMP_BYTES; i++)
      if (rd_ptr == A_TMP0 + ADDR_W'(i)) rd_byte = temp_data[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      por_flag <= 1'b1;
      ferr_q   <= 1'b0;
    end else begin
      if (frame_err)       ferr_q <= 1'b1;
      else if (good_frame) ferr_q <= 1'b0;
      if (soft_rst) begin
        ctrl_q <= '0;
        ferr_q <= 1'b0;
      end else if (wr_stb && (wr_addr == A_CTRL)) begin
        ctrl_q <= wr_data;
        if (wr_data == '0) por_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
  import spi_fd_pkg::*;
#(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] REV_ID  = 8'h13,
  parameter logic [7:0] PROD_ID = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        csb,
  input  logic        mosi,
  input  logic [47:0] axis_data,
  input  logic [15:0] temp_data,
  input  logic [7:0]  irq_flags,
  input  logic        st_flag,
  input  logic        sat_flag,
  output logic        miso,
  output logic        wr_stb,
  output logic [5:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        frame_err,
  output logic        soft_rst,
  output logic [7:0]  ctrl_q
);

  logic [DATA_W-1:0] status_byte, rd_byte;
  logic [ADDR_W-1:0] base_addr, rd_ptr;
  logic [CMD_W-1:0]  cmd_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic start_evt, end_evt, rise_evt, fall_evt, good_frame, por_flag;

  spi_fd_link #(.CNT_W(CNT_W)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi),
    .status_byte(status_byte), .rd_byte(rd_byte), .base_addr(base_addr),
    .miso(miso), .cmd_word(cmd_word), .bit_cnt(bit_cnt), .rd_ptr(rd_ptr),
    .start_evt(start_evt), .end_evt(end_evt), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  spi_fd_cmd #(.CNT_W(CNT_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .bit_cnt(bit_cnt), .cmd_word(cmd_word),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err),
    .good_frame(good_frame), .soft_rst(soft_rst), .base_addr(base_addr)
  );

  spi_fd_regs #(.REV_ID(REV_ID), .PROD_ID(PROD_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_err(frame_err), .good_frame(good_frame), .soft_rst(soft_rst), .rd_ptr(rd_ptr),
    .axis_data(axis_data), .temp_data(temp_data), .irq_flags(irq_flags),
    .st_flag(st_flag), .sat_flag(sat_flag), .rd_byte(rd_byte),
    .status_byte(status_byte), .ctrl_q(ctrl_q), .por_flag(por_flag)
  );

endmodule

// File: rtl/spi_fd_chk.sv
module spi_fd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       miso,
  input logic       wr_stb,
  input logic [5:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       frame_err,
  input logic       soft_rst,
  input logic [7:0] ctrl_q,
  input logic       por_flag,
  input logic       end_evt,
  input logic       fall_evt,
  input logic       start_evt
);

  AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == 6'h01 || wr_addr == 6'h03)); // R4

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, frame_err})); // R12

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || frame_err) |=> !(wr_stb || frame_err)); // R12

  AST_SOFT_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_stb && wr_addr == 6'h03 && wr_data == 8'h0F)); // R11

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(fall_evt || start_evt)); // R2

  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(end_evt)); // R7

  AST_CTRL_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr_stb && wr_addr == 6'h01) || $past(soft_rst)); // R5

  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(wr_stb && wr_addr == 6'h01 && wr_data == 8'h00)); // R6

  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !por_flag |=> !por_flag); // R6

endmodule

bind spi_frame_decoder spi_fd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .frame_err(frame_err), .soft_rst(soft_rst), .ctrl_q(ctrl_q),
  .por_flag(por_flag), .end_evt(end_evt), .fall_evt(fall_evt), .start_evt(start_evt)
);

// File: tb/sim_spi_frame_decoder.sv
`timescale 1ns/1ps
module sim_spi_frame_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csb = 1'b1, mosi = 1'b0;
  logic [47:0] axis_data = 48'h665544332211;
  logic [15:0] temp_data = 16'h8877;
  logic [7:0]  irq_flags = 8'h3C;
  logic st_flag = 1'b0, sat_flag = 1'b0;
  logic miso, wr_stb, frame_err, soft_rst;
  logic [5:0] wr_addr;
  logic [7:0] wr_data, ctrl_q;

  int checks = 0, errors = 0;
  int wr_cnt = 0, err_cnt = 0, soft_cnt = 0, clash_cnt = 0, wide_cnt = 0;
  logic [5:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic prev_pulse = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  spi_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi),
    .axis_data(axis_data), .temp_data(temp_data), .irq_flags(irq_flags),
    .st_flag(st_flag), .sat_flag(sat_flag), .miso(miso), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_err(frame_err),
    .soft_rst(soft_rst), .ctrl_q(ctrl_q)
  );

  always @(posedge clk) begin
    if (wr_stb) begin wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wd <= wr_data; end
    if (frame_err) err_cnt <= err_cnt + 1;
    if (soft_rst) soft_cnt <= soft_cnt + 1;
    if (wr_stb && frame_err) clash_cnt <= clash_cnt + 1;
    if ((wr_stb || frame_err) && prev_pulse) wide_cnt <= wide_cnt + 1;
    prev_pulse <= wr_stb || frame_err;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // upper byte: address, write flag, parity making the byte odd
  function automatic logic [15:0] mk(input logic [5:0] a, input logic w, input logic [7:0] d);
    logic p;
    p = 1'b1;
    for (int i = 0; i < 6; i++) p = p ^ a[i];
    p = p ^ w;
    return {a, w, p, d};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, output logic [31:0] rx);
    rx = '0;
    csb = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      rx = {rx[30:0], miso};
      mosi = word[31-i];
      sck = 1'b1;
      wclk(4);
      sck = 1'b0;
      wclk(4);
    end
    csb = 1'b1;
    wclk(12);
  endtask

  task automatic frame16(input logic [15:0] w, output logic [15:0] rx);
    logic [31:0] r;
    xfer({w, 16'h0}, 16, r);
    rx = r[15:0];
  endtask

  // {rw,0,addr} , write data , expected status byte , expected returned byte
  localparam logic [31:0] VEC [13] = '{
    32'h00_00_08_13, 32'h04_00_08_13, 32'h09_00_08_11, 32'h12_00_08_66,
    32'h13_00_08_77, 32'h16_00_08_88, 32'h27_00_08_3C, 32'h81_20_08_5A,
    32'h02_00_08_20, 32'h01_00_08_08, 32'h81_00_08_20, 32'h00_00_00_00,
    32'h02_00_00_13
  };

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    logic [31:0] rx32;
    int wr0, err0, soft0;
    wclk(3);
    // R6 reset state at the ports
    chk("R6 reset ctrl_q", 32'(ctrl_q), 32'h00);
    chk("R2 reset miso", 32'(miso), 32'h0);
    chk("R4 reset wr_stb", 32'(wr_stb), 32'h0);
    chk("R7 reset frame_err", 32'(frame_err), 32'h0);
    rst_n = 1'b1;
    wclk(4);

    // R1 R2 R3 R5 R6 table walk
    for (int k = 0; k < 13; k++) begin
      logic [5:0] a;
      logic w;
      a = VEC[k][29:24];
      w = VEC[k][31];
      wr0 = wr_cnt;
      frame16(mk(a, w, VEC[k][23:16]), rx);
      chk($sformatf("R2 status vec%0d", k), 32'(rx[15:8]), 32'(VEC[k][15:8]));
      chk($sformatf("R3 data vec%0d", k), 32'(rx[7:0]), 32'(VEC[k][7:0]));
      if (w && (a == 6'h01 || a == 6'h03)) begin
        chk($sformatf("R4 strobe vec%0d", k), 32'(wr_cnt - wr0), 32'd1);
        chk($sformatf("R1 wr fields vec%0d", k), {18'h0, last_wa, last_wd}, {18'h0, a, VEC[k][23:16]});
      end else begin
        chk($sformatf("R4 no strobe vec%0d", k), 32'(wr_cnt - wr0), 32'd0);
      end
      if (k == 7) chk("R5 ctrl load", 32'(ctrl_q), 32'h20);
    end
    chk("R5 ctrl after zero write", 32'(ctrl_q), 32'h00);

    // R4 write to a read-only address
    wr0 = wr_cnt;
    frame16(mk(6'h02, 1'b1, 8'h55), rx);
    chk("R4 read-only write ignored", 32'(wr_cnt - wr0), 32'd0);

    // R7 truncated frames
    err0 = err_cnt; wr0 = wr_cnt;
    xfer({mk(6'h01, 1'b1, 8'h08), 16'h0}, 5, rx32);
    chk("R7 short frame error", 32'(err_cnt - err0), 32'd1);
    chk("R7 short frame no write", 32'(wr_cnt - wr0), 32'd0);
    chk("R7 short frame ctrl kept", 32'(ctrl_q), 32'h00);
    err0 = err_cnt;
    xfer({mk(6'h01, 1'b1, 8'h08), 16'h0}, 8, rx32);
    chk("R7 byte frame no error", 32'(err_cnt - err0), 32'd0);
    chk("R7 byte frame ctrl kept", 32'(ctrl_q), 32'h00);

    // R9 error flag shows and clears
    frame16(mk(6'h00, 1'b0, 8'h00), rx);
    chk("R9 ferr in status", 32'(rx[15:8]), 32'h04);
    chk("R9 ferr in status reg", 32'(rx[7:0]), 32'h04);
    frame16(mk(6'h02, 1'b0, 8'h00), rx);
    chk("R9 ferr cleared", 32'(rx[15:8]), 32'h00);
    chk("R3 revision after error", 32'(rx[7:0]), 32'h13);

    // R8 parity error
    err0 = err_cnt; wr0 = wr_cnt;
    frame16(mk(6'h01, 1'b1, 8'h08) ^ 16'h0100, rx);
    chk("R8 parity error", 32'(err_cnt - err0), 32'd1);
    chk("R8 parity no write", 32'(wr_cnt - wr0), 32'd0);
    chk("R8 parity ctrl kept", 32'(ctrl_q), 32'h00);

    // R10 decrementing multi-byte read
    frame16(mk(6'h09, 1'b0, 8'h00), rx);
    err0 = err_cnt;
    xfer({mk(6'h05, 1'b0, 8'h00), 16'h0}, 32, rx32);
    chk("R10 status byte", 32'(rx32[31:24]), 32'h00);
    chk("R10 byte1", 32'(rx32[23:16]), 32'h66);
    chk("R10 byte2", 32'(rx32[15:8]), 32'h55);
    chk("R10 byte3", 32'(rx32[7:0]), 32'h44);
    chk("R10 no error", 32'(err_cnt - err0), 32'd0);
    frame16(mk(6'h00, 1'b0, 8'h00), rx);
    chk("R10 next frame uses own address", 32'(rx[7:0]), 32'h22);

    // R11 soft reset key
    frame16(mk(6'h01, 1'b1, 8'h04), rx);
    chk("R5 ctrl 04", 32'(ctrl_q), 32'h04);
    soft0 = soft_cnt;
    frame16(mk(6'h03, 1'b1, 8'h0C), rx);
    frame16(mk(6'h03, 1'b1, 8'h05), rx);
    chk("R11 no early soft reset", 32'(soft_cnt - soft0), 32'd0);
    frame16(mk(6'h03, 1'b1, 8'h0F), rx);
    chk("R11 soft reset pulse", 32'(soft_cnt - soft0), 32'd1);
    chk("R11 ctrl cleared", 32'(ctrl_q), 32'h00);
    frame16(mk(6'h00, 1'b0, 8'h00), rx);
    chk("R6 soft reset keeps por clear", 32'(rx[15:8]), 32'h00);
    soft0 = soft_cnt;
    frame16(mk(6'h03, 1'b1, 8'h0C), rx);
    frame16(mk(6'h03, 1'b1, 8'h07), rx);
    frame16(mk(6'h03, 1'b1, 8'h0F), rx);
    chk("R11 wrong value restarts", 32'(soft_cnt - soft0), 32'd0);
    frame16(mk(6'h03, 1'b1, 8'h0C), rx);
    frame16(mk(6'h00, 1'b0, 8'h00), rx);
    frame16(mk(6'h03, 1'b1, 8'h05), rx);
    frame16(mk(6'h03, 1'b1, 8'h0F), rx);
    chk("R11 other frame restarts", 32'(soft_cnt - soft0), 32'd0);

    // R12 pulse shape over the whole run
    chk("R12 no strobe with error", 32'(clash_cnt), 32'd0);
    chk("R12 single-cycle pulses", 32'(wide_cnt), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule